// File: doc/BRIEF.md
# Triangle Spread-Spectrum Modulation Generator

This block produces a signed frequency-offset word whose value traces a symmetric triangle around zero, once per modulation period. A fractional divider or numerically controlled oscillator downstream adds the word to its nominal increment, so that the synthesized clock is spread evenly above and below its centre frequency. The block runs on the reference clock, and the modulation rate is the reference frequency divided by the period length.

A 2-bit range code selects the period length and reports the output multiplier. Two pre-decoded three-level select inputs form one of nine amplitude steps. An enable input starts and stops the modulation. A second offset word serves an output running at half the primary frequency, so that output keeps the same relative spread. Range and amplitude are applied only at period boundaries, or at once while modulation is idle.

Top module: `tri_mod_gen`

## Requirements
- R1: With active range code 2'b00 or 2'b01 the offset pattern repeats every CDIV (1166) reference cycles. With range code 2'b10 it repeats every 2*CDIV (2332) cycles.
- R2: For phase q counted from 0 at the period start, H = CDIV/2 and P = H-1, the triangle index is t = 2q-P when q < H and t = P-2(q-H) otherwise. offset_o = t*A. For range 2'b10, q is the cycle count within the period halved (rounded down), so each value is held for two cycles.
- R3: The peaks are symmetric. The maximum is +P*A, the minimum is -P*A, and the period starts at the minimum.
- R4: Each select trit is encoded 2'b00 = low (0), 2'b01 = middle (1), 2'b10 = high (2), and 2'b11 is taken as high. The amplitude is A = 3*sel1 + sel0 + 1, in the range 1..9.
- R5: mult2x_o is high exactly when the active range code is 2'b01. It is never high together with cfg_invalid_o.
- R6: Range code 2'b11 is invalid. Once it is latched, cfg_invalid_o goes high and offset_o stays 0. When a valid code is latched, the flag clears and the triangle starts at its minimum.
- R7: When mod_en_i is sampled low, offset_o is 0 from the next cycle on. When it is sampled high again, the triangle restarts at phase 0, which is the minimum.
- R8: While modulation runs, changes of range or amplitude take effect only at the first cycle of the next period.
- R9: half_offset_o equals offset_o divided by two, with no remainder.
- R10: During and after reset, offset_o and half_offset_o are 0 and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_i | input | 2 | Range code: 00 = 1X, 01 = 2X, 10 = long period 1X, 11 = invalid |
| mod_en_i | input | 1 | Modulation enable, active high |
| amp_sel0_i | input | 2 | Amplitude select trit, low digit |
| amp_sel1_i | input | 2 | Amplitude select trit, high digit |
| offset_o | output | OFF_W | Signed frequency offset for the primary output |
| half_offset_o | output | OFF_W | Signed offset for the half-rate output |
| mult2x_o | output | 1 | Primary output multiplier is 2X |
| cfg_invalid_o | output | 1 | Latched range code is invalid |

## Verification
Six range and amplitude combinations are each swept for one and a half periods and compared sample by sample with the triangle formula. Between them they cover both period lengths, low, middle and high trit values, and the 2'b11 trit code, so an error in period length, in sample holding, in trit weighting or in peak symmetry shows up as a sample mismatch. Directed cases then disable the block mid-sweep and re-enable it, pass through an invalid range, and change the configuration mid-period. The last case tells a change applied at the boundary apart from one applied at once.

// File: rtl/tri_mod_pkg.sv
package tri_mod_pkg;

  typedef enum logic [1:0] {
    RNG_1X   = 2'b00,
    RNG_2X   = 2'b01,
    RNG_LONG = 2'b10,
    RNG_BAD  = 2'b11
  } rng_e;

  typedef struct packed {
    rng_e       rng;
    logic [3:0] amp;
  } cfg_t;

  localparam cfg_t CFG_RST = '{rng: RNG_1X, amp: 4'd1};

  // three-level code to digit; 2'b11 saturates to high
  function automatic logic [1:0] trit_val(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/tri_cfg_decode.sv
module tri_cfg_decode
  import tri_mod_pkg::*;
(
  input  logic [1:0] range_i,
  input  logic [1:0] sel0_i,
  input  logic [1:0] sel1_i,
  output cfg_t       cfg_o,
  output logic       valid_o
);

  logic [1:0] d0, d1;

  always_comb begin
    d0          = trit_val(sel0_i);
    d1          = trit_val(sel1_i);
    cfg_o.rng   = rng_e'(range_i);
    cfg_o.amp   = {2'b00, d1} * 4'd3 + {2'b00, d0} + 4'd1;
    valid_o     = (range_i != RNG_BAD);
  end

endmodule

// File: rtl/tri_phase_ctrl.sv
module tri_phase_ctrl
  import tri_mod_pkg::*;
#(
  parameter int CDIV = 1166,
  localparam int PH_W = $clog2(2 * CDIV)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  cfg_t            cfg_i,
  input  logic            valid_i,
  output logic            run_o,
  output logic [PH_W-1:0] phase_o,
  output cfg_t            cfg_q_o
);

  localparam logic [PH_W-1:0] LAST_SHORT = PH_W'(CDIV - 1);
  localparam logic [PH_W-1:0] LAST_LONG  = PH_W'(2 * CDIV - 1);

  logic            run_q;
  logic [PH_W-1:0] phase_q;
  cfg_t            cfg_q;
  logic [PH_W-1:0] last;
  logic            upd;

  always_comb begin
    last = (cfg_q.rng == RNG_LONG) ? LAST_LONG : LAST_SHORT;
    upd  = !run_q || (phase_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      cfg_q   <= CFG_RST;
    end else begin
      if (upd) cfg_q <= cfg_i;
      if (!en_i) begin
        run_q   <= 1'b0;
        phase_q <= '0;
      end else if (upd) begin
        run_q   <= valid_i;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign run_o   = run_q;
  assign phase_o = phase_q;
  assign cfg_q_o = cfg_q;

endmodule

// File: rtl/tri_wave_shape.sv
module tri_wave_shape
  import tri_mod_pkg::*;
#(
  parameter int CDIV  = 1166,
  parameter int OFF_W = 16,
  localparam int PH_W = $clog2(2 * CDIV)
) (
  input  logic                    run_i,
  input  logic [PH_W-1:0]         phase_i,
  input  cfg_t                    cfg_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic signed [OFF_W-1:0] half_o
);

  localparam int HALF = CDIV / 2;
  localparam int TW   = PH_W + 2;
  localparam logic signed [TW-1:0] PEAK_S = TW'(HALF - 1);
  localparam logic signed [TW-1:0] TOP_S  = TW'(HALF - 1 + 2 * HALF);

  logic [PH_W-1:0]         q;
  logic signed [TW-1:0]    q_s;
  logic signed [TW-1:0]    t;
  logic signed [OFF_W-1:0] t_ext, a_ext, prod;

  always_comb begin
    // long range holds each value for two cycles
    q     = (cfg_i.rng == RNG_LONG) ? (phase_i >> 1) : phase_i;
    q_s   = signed'({2'b00, q});
    if (q < PH_W'(HALF)) t = (q_s <<< 1) - PEAK_S;
    else                 t = TOP_S - (q_s <<< 1);
    t_ext = OFF_W'(t);
    a_ext = signed'(OFF_W'(cfg_i.amp));
    prod  = t_ext * a_ext;
    offset_o = run_i ? prod : '0;
    half_o   = offset_o >>> 1;
  end

endmodule

// File: rtl/tri_mod_gen.sv
module tri_mod_gen
  import tri_mod_pkg::*;
#(
  parameter int CDIV  = 1166,
  parameter int OFF_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              range_i,
  input  logic                    mod_en_i,
  input  logic [1:0]              amp_sel0_i,
  input  logic [1:0]              amp_sel1_i,
  output logic signed [OFF_W-1:0] offset_o,
  output logic signed [OFF_W-1:0] half_offset_o,
  output logic                    mult2x_o,
  output logic                    cfg_invalid_o
);

  localparam int PH_W = $clog2(2 * CDIV);

  cfg_t            cfg_in, cfg_q;
  logic            cfg_ok;
  logic            run;
  logic [PH_W-1:0] phase;

  tri_cfg_decode u_dec (
    .range_i (range_i),
    .sel0_i  (amp_sel0_i),
    .sel1_i  (amp_sel1_i),
    .cfg_o   (cfg_in),
    .valid_o (cfg_ok)
  );

  tri_phase_ctrl #(.CDIV(CDIV)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mod_en_i),
    .cfg_i   (cfg_in),
    .valid_i (cfg_ok),
    .run_o   (run),
    .phase_o (phase),
    .cfg_q_o (cfg_q)
  );

  tri_wave_shape #(.CDIV(CDIV), .OFF_W(OFF_W)) u_wave (
    .run_i    (run),
    .phase_i  (phase),
    .cfg_i    (cfg_q),
    .offset_o (offset_o),
    .half_o   (half_offset_o)
  );

  assign mult2x_o      = (cfg_q.rng == RNG_2X);
  assign cfg_invalid_o = (cfg_q.rng == RNG_BAD);

endmodule

// File: rtl/tri_mod_gen_chk.sv
module tri_mod_gen_chk #(
  parameter int CDIV  = 1166,
  parameter int OFF_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    mod_en_i,
  input logic signed [OFF_W-1:0] offset_o,
  input logic signed [OFF_W-1:0] half_offset_o,
  input logic                    mult2x_o,
  input logic                    cfg_invalid_o
);

  localparam int PK = (CDIV / 2 - 1) * 9;

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> (offset_o == '0)); // R7

  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_invalid_o |-> (offset_o == '0)); // R6

  AST_INVALID_EXIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_invalid_o) |-> (offset_o <= 0)); // R6

  AST_HALF_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OFF_W'(half_offset_o + half_offset_o) == offset_o)); // R9

  AST_PEAK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(offset_o) <= PK) && (int'(offset_o) >= -PK)); // R3

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mult2x_o && cfg_invalid_o)); // R5

endmodule

bind tri_mod_gen tri_mod_gen_chk #(.CDIV(CDIV), .OFF_W(OFF_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mod_en_i      (mod_en_i),
  .offset_o      (offset_o),
  .half_offset_o (half_offset_o),
  .mult2x_o      (mult2x_o),
  .cfg_invalid_o (cfg_invalid_o)
);

// File: tb/tri_mod_gen_test.sv
module tri_mod_gen_test;

  localparam int CLK_P = 10;
  localparam int CDIV  = 1166;
  localparam int OFF_W = 16;
  localparam int HALF  = CDIV / 2;
  localparam int P     = HALF - 1;

  typedef struct packed {
    logic [1:0] rng;
    logic [1:0] s0;
    logic [1:0] s1;
    int         amp;
    int         per;
    logic       m2;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{rng: 2'b00, s0: 2'b00, s1: 2'b00, amp: 1, per: CDIV,     m2: 1'b0},
    '{rng: 2'b00, s0: 2'b10, s1: 2'b10, amp: 9, per: CDIV,     m2: 1'b0},
    '{rng: 2'b01, s0: 2'b01, s1: 2'b00, amp: 2, per: CDIV,     m2: 1'b1},
    '{rng: 2'b10, s0: 2'b00, s1: 2'b01, amp: 4, per: 2 * CDIV, m2: 1'b0},
    '{rng: 2'b10, s0: 2'b10, s1: 2'b01, amp: 6, per: 2 * CDIV, m2: 1'b0},
    '{rng: 2'b01, s0: 2'b11, s1: 2'b10, amp: 9, per: CDIV,     m2: 1'b1}
  };

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [1:0]              range_in = 2'b00;
  logic                    mod_en = 1'b1;
  logic [1:0]              sel0 = 2'b00;
  logic [1:0]              sel1 = 2'b00;
  logic signed [OFF_W-1:0] offset, half_offset;
  logic                    mult2x, cfg_invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_P / 2) clk = ~clk;

  tri_mod_gen #(.CDIV(CDIV), .OFF_W(OFF_W)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .range_i       (range_in),
    .mod_en_i      (mod_en),
    .amp_sel0_i    (sel0),
    .amp_sel1_i    (sel1),
    .offset_o      (offset),
    .half_offset_o (half_offset),
    .mult2x_o      (mult2x),
    .cfg_invalid_o (cfg_invalid)
  );

  // expected triangle from the requirement formula
  function automatic int exp_off(int per, int amp, int k);
    int ph, q, t;
    ph = k % per;
    q  = (per == 2 * CDIV) ? ph / 2 : ph;
    t  = (q < HALF) ? 2 * q - P : P - 2 * (q - HALF);
    return t * amp;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int mx, mn;
    // R10 reset state
    repeat (3) step();
    chk("R10 offset", int'(offset), 0);
    chk("R10 half", int'(half_offset), 0);
    chk("R10 mult2x", int'(mult2x), 0);
    chk("R10 invalid", int'(cfg_invalid), 0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 6; i++) begin
      mod_en   = 1'b0;
      range_in = VEC[i].rng;
      sel0     = VEC[i].s0;
      sel1     = VEC[i].s1;
      step();
      mod_en = 1'b1;
      step();
      chk("R5 mult2x", int'(mult2x), int'(VEC[i].m2));
      mx = -100000;
      mn = 100000;
      for (int k = 0; k <= VEC[i].per + VEC[i].per / 2; k++) begin
        chk("R2 sample", int'(offset), exp_off(VEC[i].per, VEC[i].amp, k));
        if (k == VEC[i].per) chk("R1 period restart", int'(offset), -P * VEC[i].amp);
        if (k == 10) chk("R9 half", int'(half_offset), int'(offset) / 2);
        if (int'(offset) > mx) mx = int'(offset);
        if (int'(offset) < mn) mn = int'(offset);
        step();
      end
      chk("R3 max", mx, P * VEC[i].amp);
      chk("R3 min", mn, -P * VEC[i].amp);
      chk("R4 amplitude", mx / P, VEC[i].amp);
    end

    // R7 disable mid-run, then re-enable
    mod_en = 1'b0; range_in = 2'b00; sel0 = 2'b01; sel1 = 2'b01;
    step();
    mod_en = 1'b1;
    step();
    repeat (200) step();
    mod_en = 1'b0;
    step();
    chk("R7 off after disable", int'(offset), 0);
    repeat (3) step();
    chk("R7 still off", int'(offset), 0);
    mod_en = 1'b1;
    step();
    chk("R7 restart at minimum", int'(offset), -P * 5);
    step();
    chk("R7 second sample", int'(offset), -P * 5 + 10);

    // R6 invalid range
    mod_en = 1'b0;
    step();
    range_in = 2'b11; mod_en = 1'b1;
    step();
    chk("R6 invalid flag", int'(cfg_invalid), 1);
    chk("R6 offset zero", int'(offset), 0);
    chk("R5 no mult2x when invalid", int'(mult2x), 0);
    repeat (5) step();
    chk("R6 offset held zero", int'(offset), 0);
    range_in = 2'b00;
    step();
    chk("R6 flag cleared", int'(cfg_invalid), 0);
    chk("R6 start at minimum", int'(offset), -P * 5);

    // R8 mid-period change applies at the boundary
    mod_en = 1'b0; range_in = 2'b00; sel0 = 2'b00; sel1 = 2'b00;
    step();
    mod_en = 1'b1;
    step();
    for (int k = 0; k < CDIV + 3; k++) begin
      if (k == 100) begin
        range_in = 2'b10; sel0 = 2'b10; sel1 = 2'b10;
      end
      if (k == 500)      chk("R8 old config kept", int'(offset), exp_off(CDIV, 1, 500));
      if (k == CDIV - 1) chk("R8 old end value", int'(offset), -P);
      if (k == CDIV)     chk("R8 new start", int'(offset), -P * 9);
      if (k == CDIV + 1) chk("R8 long hold", int'(offset), -P * 9);
      if (k == CDIV + 2) chk("R8 long step", int'(offset), -P * 9 + 18);
      step();
    end
    chk("R5 mult2x long range", int'(mult2x), 0);

    finish_run();
  end

endmodule